// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage

This block is one stage of a pipelined radix-2 FFT built as a single path with a delay-feedback loop. Complex samples arrive one per transfer. A phase counter alternates two halves of every block of `2*DEPTH` transfers. In the fill half, the incoming sample is parked in a feedback loop of `DEPTH` transfers, and the sample leaving that loop goes to the output. In the butterfly half, the sample leaving the loop is combined with the new one. Their sum goes to the output and their difference goes back into the loop.

The loop delay can be split, to ease timing, into three parts: a register in front of the butterfly input (`IN_DLY`), a register after the butterfly's loop-bound result (`OUT_DLY`), and a shift line of `DEPTH - IN_DLY - OUT_DLY` entries. Every part advances only when a transfer takes place. The function seen at the ports is therefore identical for every legal split.

The stream interface uses valid/ready handshakes. A transfer happens in a cycle where `in_valid` and `out_ready` are both high. The stage passes the handshake straight through: `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle. Downstream back-pressure therefore stalls the upstream source without any buffering. Twiddle multiplication, reordering and scaling belong to other blocks.

Top module: `r2sdf_stage`

## Requirements
- R1: `in_ready` equals `out_ready` and `out_valid` equals `in_valid` in every cycle. A transfer occurs exactly in cycles where `in_valid` and `out_ready` are both high.
- R2: Transfers are numbered from 0 after reset. Transfer k is in the fill phase when (k mod 2*DEPTH) < DEPTH, and in the butterfly phase otherwise.
- R3: In the fill phase, the output equals the sample leaving the feedback loop, and the new input, sign-extended to DW+1 bits, enters the loop.
- R4: In the butterfly phase, the output equals the loop sample plus the new input, and the loop sample minus the new input enters the loop.
- R5: A value entering the loop leaves it exactly DEPTH transfers later. This holds for each combination of `IN_DLY` and `OUT_DLY`, each 0 or 1 with default 0, provided DEPTH >= IN_DLY + OUT_DLY. The shift line then holds DEPTH - IN_DLY - OUT_DLY entries.
- R6: A cycle without a transfer changes no stored state. In the fill phase, the outputs hold their value across such cycles.
- R7: Synchronous reset returns the phase to fill and clears all loop storage to zero. Both outputs are therefore zero during the first DEPTH transfers after reset.
- R8: Outputs are DW+1-bit two's complement. Full-scale inputs (-2^(DW-1) and 2^(DW-1)-1) give exact sums and differences. The real and imaginary parts are processed by identical, independent logic.
- R9: With `IN_DLY` = `OUT_DLY` = 0, the butterfly is combinational. In the butterfly phase, a change of the input data shows at the output in the same cycle, even without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Stage can take the input sample |
| in_re | input | DW | Real part of input, signed |
| in_im | input | DW | Imaginary part of input, signed |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_re | output | DW+1 | Real part of output, signed |
| out_im | output | DW+1 | Imaginary part of output, signed |

## Verification
The hardest case to reach is a stall that falls in the butterfly half while the retimed registers hold values that are only part-way round the loop. A split with a wrong enable then corrupts data that surfaces only DEPTH transfers later. The second hard case is a depth-1 stage whose shift line has zero length. The bench drives one stimulus into five stage instances: four splits of a depth-4 loop and a depth-1 loop made entirely of a retimed register. Valid gaps and back-pressure are inserted in both phases, and every instance is compared against one reference model for its depth.

// File: rtl/r2sdf_pkg.sv
package r2sdf_pkg;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_BFLY = 1'b1
  } phase_e;

  // length of the plain shift line once retimed registers are taken out
  function automatic int line_len(int depth, int pre, int post);
    int n;
    n = depth - pre - post;
    return (n < 0) ? 0 : n;
  endfunction

endpackage

// File: rtl/r2sdf_vdelay.sv
module r2sdf_vdelay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (N == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = &{1'b0, clk, rst, en};
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] tap [N];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < N; i++) tap[i] <= '0;
        end else if (en) begin
          tap[0] <= d;
          for (int i = 1; i < N; i++) tap[i] <= tap[i-1];
        end
      end
      assign q = tap[N-1];
    end
  endgenerate

endmodule

// File: rtl/r2sdf_phase.sv
module r2sdf_phase
  import r2sdf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  output phase_e ph
);

  localparam int PERIOD = 2 * DEPTH;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assign ph = (cnt >= CW'(DEPTH)) ? PH_BFLY : PH_FILL;

endmodule

// File: rtl/r2sdf_bfly.sv
module r2sdf_bfly
  import r2sdf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW:0]   loop_in,
  input  logic [DW-1:0] new_in,
  input  phase_e        ph,
  output logic [DW:0]   res_out,
  output logic [DW:0]   res_loop
);

  localparam int AW = DW + 1;

  logic signed [AW:0] ax, bx, sum, dif;
  logic               unused_msb;

  assign ax  = {loop_in[AW-1], loop_in};
  assign bx  = {{(AW + 1 - DW){new_in[DW-1]}}, new_in};
  assign sum = ax + bx;
  assign dif = ax - bx;
  assign unused_msb = sum[AW] ^ dif[AW];

  always_comb begin
    if (ph == PH_BFLY) begin
      res_out  = sum[AW-1:0];
      res_loop = dif[AW-1:0];
    end else begin
      res_out  = loop_in;
      res_loop = bx[AW-1:0];
    end
  end

endmodule

// File: rtl/r2sdf_stage.sv
module r2sdf_stage
  import r2sdf_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DEPTH   = 8,
  parameter int IN_DLY  = 0,
  parameter int OUT_DLY = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_re,
  output logic [DW:0]   out_im
);

  localparam int AW     = DW + 1;
  localparam int LINE_D = line_len(DEPTH, IN_DLY, OUT_DLY);

  generate
    if (DEPTH < 1 || IN_DLY > 1 || OUT_DLY > 1 || IN_DLY < 0 || OUT_DLY < 0 ||
        DEPTH < IN_DLY + OUT_DLY) begin : g_bad_cfg
      $error("r2sdf_stage: illegal depth or delay split");
    end
  endgenerate

  logic   fire;
  phase_e ph;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid & out_ready;

  r2sdf_phase #(.DEPTH(DEPTH)) u_phase (
    .clk(clk), .rst(rst), .en(fire), .ph(ph)
  );

  logic [DW-1:0] lane_in  [2];
  logic [AW-1:0] lane_out [2];

  assign lane_in[0] = in_re;
  assign lane_in[1] = in_im;
  assign out_re     = lane_out[0];
  assign out_im     = lane_out[1];

  generate
    for (genvar k = 0; k < 2; k++) begin : g_lane
      logic [AW-1:0] head, a_op, fb_bf, fb_line;

      r2sdf_vdelay #(.W(AW), .N(IN_DLY)) u_pre (
        .clk(clk), .rst(rst), .en(fire), .d(head), .q(a_op)
      );

      r2sdf_bfly #(.DW(DW)) u_bfly (
        .loop_in(a_op), .new_in(lane_in[k]), .ph(ph),
        .res_out(lane_out[k]), .res_loop(fb_bf)
      );

      r2sdf_vdelay #(.W(AW), .N(OUT_DLY)) u_post (
        .clk(clk), .rst(rst), .en(fire), .d(fb_bf), .q(fb_line)
      );

      r2sdf_vdelay #(.W(AW), .N(LINE_D)) u_line (
        .clk(clk), .rst(rst), .en(fire), .d(fb_line), .q(head)
      );
    end
  endgenerate

endmodule

// File: rtl/r2sdf_stage_chk.sv
module r2sdf_stage_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_re,
  input logic [DW-1:0] in_im,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW:0]   out_re,
  input logic [DW:0]   out_im
);

  localparam int AW = DW + 1;

  logic                 fire, bph, unused_rdy;
  logic signed [AW-1:0] mre [DEPTH];
  logic signed [AW-1:0] mim [DEPTH];
  logic signed [AW-1:0] bre, bim, exp_re, exp_im, fb_re, fb_im;
  int                   pos, seen;

  assign unused_rdy = in_ready;
  assign fire   = in_valid && out_ready;
  assign bph    = pos >= DEPTH;
  assign bre    = AW'($signed(in_re));
  assign bim    = AW'($signed(in_im));
  assign exp_re = bph ? mre[DEPTH-1] + bre : mre[DEPTH-1];
  assign exp_im = bph ? mim[DEPTH-1] + bim : mim[DEPTH-1];
  assign fb_re  = bph ? mre[DEPTH-1] - bre : bre;
  assign fb_im  = bph ? mim[DEPTH-1] - bim : bim;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) begin
        mre[j] <= '0;
        mim[j] <= '0;
      end
      pos  <= 0;
      seen <= 0;
    end else if (fire) begin
      for (int j = DEPTH - 1; j > 0; j--) begin
        mre[j] <= mre[j-1];
        mim[j] <= mim[j-1];
      end
      mre[0] <= fb_re;
      mim[0] <= fb_im;
      pos    <= (pos == 2 * DEPTH - 1) ? 0 : pos + 1;
      if (seen < DEPTH) seen <= seen + 1;
    end
  end

  // R4
  re_model_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_re == exp_re);

  // R8
  im_model_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_im == exp_im);

  // R7
  first_block_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (seen < DEPTH) |-> (out_re == '0 && out_im == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fire && !bph) |=> ($stable(out_re) && $stable(out_im)));

endmodule

bind r2sdf_stage r2sdf_stage_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_r2sdf_stage.sv
`timescale 1ns/1ps
module sim_r2sdf_stage;

  localparam int DW = 8;
  localparam int NI = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [DW-1:0] in_re = '0;
  logic [DW-1:0] in_im = '0;

  logic          irdy [NI];
  logic          oval [NI];
  logic [DW:0]   ore  [NI];
  logic [DW:0]   oim  [NI];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  r2sdf_stage #(.DW(DW), .DEPTH(4), .IN_DLY(0), .OUT_DLY(0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(irdy[0]), .in_re(in_re), .in_im(in_im),
    .out_valid(oval[0]), .out_ready(out_ready), .out_re(ore[0]), .out_im(oim[0]));
  r2sdf_stage #(.DW(DW), .DEPTH(4), .IN_DLY(1), .OUT_DLY(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(irdy[1]), .in_re(in_re), .in_im(in_im),
    .out_valid(oval[1]), .out_ready(out_ready), .out_re(ore[1]), .out_im(oim[1]));
  r2sdf_stage #(.DW(DW), .DEPTH(4), .IN_DLY(0), .OUT_DLY(1)) u2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(irdy[2]), .in_re(in_re), .in_im(in_im),
    .out_valid(oval[2]), .out_ready(out_ready), .out_re(ore[2]), .out_im(oim[2]));
  r2sdf_stage #(.DW(DW), .DEPTH(4), .IN_DLY(1), .OUT_DLY(1)) u3 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(irdy[3]), .in_re(in_re), .in_im(in_im),
    .out_valid(oval[3]), .out_ready(out_ready), .out_re(ore[3]), .out_im(oim[3]));
  r2sdf_stage #(.DW(DW), .DEPTH(1), .IN_DLY(0), .OUT_DLY(1)) u4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(irdy[4]), .in_re(in_re), .in_im(in_im),
    .out_valid(oval[4]), .out_ready(out_ready), .out_re(ore[4]), .out_im(oim[4]));

  // reference model, one per instance
  int mfr [NI][4];
  int mfi [NI][4];
  int mcnt [NI];

  function automatic int dep(int m);
    return (m == 4) ? 1 : 4;
  endfunction

  function automatic bit bfly_phase(int m);
    return (mcnt[m] % (2 * dep(m))) >= dep(m);
  endfunction

  task automatic model_reset();
    for (int m = 0; m < NI; m++) begin
      mcnt[m] = 0;
      for (int j = 0; j < 4; j++) begin
        mfr[m][j] = 0;
        mfi[m][j] = 0;
      end
    end
  endtask

  task automatic model_fire(int m, int re, int im);
    int hr, hi, dr, di;
    hr = mfr[m][dep(m)-1];
    hi = mfi[m][dep(m)-1];
    dr = bfly_phase(m) ? hr - re : re;
    di = bfly_phase(m) ? hi - im : im;
    for (int j = dep(m) - 1; j > 0; j--) begin
      mfr[m][j] = mfr[m][j-1];
      mfi[m][j] = mfi[m][j-1];
    end
    mfr[m][0] = dr;
    mfi[m][0] = di;
    mcnt[m]++;
  endtask

  task automatic check(bit ok, string req, int m, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s u%0d actual=%0d expected=%0d", req, m, act, exp);
    end
  endtask

  // one cycle: drive, compare outputs before the edge, advance model after it
  task automatic step(bit v, bit r, int re, int im, string tag);
    int er, ei;
    @(negedge clk);
    in_valid  = v;
    out_ready = r;
    in_re     = re[DW-1:0];
    in_im     = im[DW-1:0];
    #1;
    for (int m = 0; m < NI; m++) begin
      er = mfr[m][dep(m)-1] + (bfly_phase(m) ? re : 0);
      ei = mfi[m][dep(m)-1] + (bfly_phase(m) ? im : 0);
      check($signed(ore[m]) == er, (m == 0) ? tag : {tag, " R5"}, m, $signed(ore[m]), er);
      check($signed(oim[m]) == ei, (m == 0) ? {tag, " R8"} : {tag, " R5"}, m, $signed(oim[m]), ei);
      check(oval[m] == v && irdy[m] == r, "R1", m, {oval[m], irdy[m]}, {v, r});
    end
    @(posedge clk);
    if (v && r)
      for (int m = 0; m < NI; m++) model_fire(m, re, im);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic int rnd();
    return $urandom_range(255) - 128;
  endfunction

  function automatic string ptag(int m);
    return bfly_phase(m) ? "R2 R4" : "R2 R3";
  endfunction

  task automatic t_reset();
    do_reset();
    // R7: outputs zero right after reset, whatever the input
    step(1'b0, 1'b1, 55, -33, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, rnd(), rnd(), "R7");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, rnd(), rnd(), ptag(0));
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 60; i++) begin
      bit v, r;
      v = ($urandom_range(3) != 0);
      r = ($urandom_range(4) != 0);
      step(v, r, rnd(), rnd(), (v && r) ? ptag(0) : "R6");
    end
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 16; i++) begin
      int a, b;
      a = (i % 3 == 0) ? -128 : 127;
      b = (i % 2 == 0) ? -128 : 127;
      step(1'b1, 1'b1, a, b, "R8");
    end
  endtask

  task automatic t_comb();
    // bring u0 to the butterfly phase, then vary the data without a transfer
    while (!bfly_phase(0)) step(1'b1, 1'b1, rnd(), rnd(), "R2");
    step(1'b0, 1'b1, 17, -9, "R9");
    step(1'b1, 1'b0, -100, 100, "R9");
    step(1'b0, 1'b0, 3, 4, "R9");
    step(1'b1, 1'b1, 5, 6, "R9");
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, rnd(), rnd(), ptag(0));
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, rnd(), rnd(), "R7");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, rnd(), rnd(), ptag(0));
  endtask

  initial begin
    model_reset();
    t_reset();
    t_stream();
    t_gaps();
    t_extremes();
    t_comb();
    t_midreset();
    t_gaps();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule